// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block collects a word of level-sensitive interrupt request lines and splits it into groups of adjacent lines. With the default parameters there are 32 lines in four groups of eight. Each line has an enable bit. A line is pending when its request is high and its enable bit is set. Each group drives one combined request toward a parent interrupt controller. The combined request is high whenever any line in that group is pending.

Software controls the enables through a small register port. Writing ones to one address turns enables on. Writing ones to another address turns them off. Bits written as zero leave their enable unchanged at either address. A third address returns the pending word.

To help a handler find the source quickly, each group also presents the index of its lowest-numbered pending line. A valid flag goes with the index and is low when the group has nothing pending. Because the lines are level-sensitive, a line stays pending for as long as its request is held high and it remains enabled.

Top module: `irqcmb_top`

## Requirements
- R1: In the cycle after reset is released, every enable bit is 0, and every combined output, valid flag and index is 0.
- R2: A write to byte offset 0x0 sets each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R3: A write to byte offset 0x4 clears each enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A read of byte offset 0xC returns the bitwise AND of `irq_in` and the enable mask. The value is sampled in the read cycle. A pending line stays reported for as long as its input is held high.
- R5: Group g covers bits 8*g+7 down to 8*g, where 8 is the group width. `grp_irq[g]` is the OR of that group's pending bits, registered one clock after the pending word.
- R6: `grp_idx[3*g+2:3*g]` is the position (0 to 7) of the lowest set pending bit of group g, registered one clock after the pending word. `grp_vld[g]` is 1 exactly when that group has a pending bit. The index is 0 when the flag is 0.
- R7: A read of offset 0x0 or 0x4 returns the enable mask. A read of any offset other than 0x0, 0x4 and 0xC returns 0. A write to such an offset changes no enable bit. Read data appears on `rd_data` in the cycle after `rd_en` and is 0 in a cycle after no read.
- R8: A write to offset 0xC changes no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| grp_irq | output | 4 | Combined request per group |
| grp_idx | output | 12 | Lowest pending bit index per group, 3 bits each |
| grp_vld | output | 4 | Index valid per group |

## Verification
The hardest case to reach from the ports is a group with several pending bits at once, where the reported index must be the lowest of them. Reaching it needs both the right enable pattern and the right request pattern at the same moment. The lowest pending bit must also shift when a lower line is disabled or dropped. The stimulus builds up random enable masks through interleaved set and clear writes, applies dense random request words, and adds directed patterns. The directed patterns place pending bits only at the top bit of a group, only at the bottom bit, and at several bits within one group. A line is then cleared beneath another pending line to force the index to move.

// File: rtl/irqcmb_pkg.sv
package irqcmb_pkg;
  localparam int unsigned OFS_EN_SET = 32'h0;
  localparam int unsigned OFS_EN_CLR = 32'h4;
  localparam int unsigned OFS_STATUS = 32'hC;

  typedef enum logic [1:0] {
    ACC_UNDEF = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLR   = 2'd2,
    ACC_STAT  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/irqcmb_regs.sv
module irqcmb_regs
  import irqcmb_pkg::*;
#(
  parameter int unsigned NG     = 4,
  parameter int unsigned GW     = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DW    = NG * GW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     status_i,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     en_mask
);
  acc_kind_e kind;

  always_comb begin
    if (32'(addr) == OFS_EN_SET)      kind = ACC_SET;
    else if (32'(addr) == OFS_EN_CLR) kind = ACC_CLR;
    else if (32'(addr) == OFS_STATUS) kind = ACC_STAT;
    else                              kind = ACC_UNDEF;
  end

  // enable mask: only set/clear addresses can touch it
  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask <= '0;
    end else if (wr_en) begin
      case (kind)
        ACC_SET: en_mask <= en_mask | wr_data;
        ACC_CLR: en_mask <= en_mask & ~wr_data;
        default: en_mask <= en_mask;
      endcase
    end
  end

  logic [DW-1:0] rd_mux;

  always_comb begin
    case (kind)
      ACC_SET, ACC_CLR: rd_mux = en_mask;
      ACC_STAT:         rd_mux = status_i;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end
endmodule

// File: rtl/irqcmb_group.sv
module irqcmb_group #(
  parameter int unsigned GW    = 8,
  localparam int unsigned IDX_W = (GW > 1) ? $clog2(GW) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GW-1:0]    pend,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  logic [IDX_W-1:0] low_idx;
  logic             any;

  // lowest set bit: scan downward so the lowest match wins
  always_comb begin
    low_idx = '0;
    for (int i = GW - 1; i >= 0; i--) begin
      if (pend[i]) low_idx = i[IDX_W-1:0];
    end
    any = |pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      idx_o <= '0;
      vld_o <= 1'b0;
    end else begin
      irq_o <= any;
      idx_o <= any ? low_idx : '0;
      vld_o <= any;
    end
  end
endmodule

// File: rtl/irqcmb_top.sv
module irqcmb_top
  import irqcmb_pkg::*;
#(
  parameter int unsigned NG     = 4,
  parameter int unsigned GW     = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DW    = NG * GW,
  localparam int unsigned IDX_W = (GW > 1) ? $clog2(GW) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DW-1:0]       irq_in,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic [NG-1:0]       grp_irq,
  output logic [NG*IDX_W-1:0] grp_idx,
  output logic [NG-1:0]       grp_vld
);
  logic [DW-1:0] en_mask;
  logic [DW-1:0] status;

  assign status = irq_in & en_mask;

  irqcmb_regs #(.NG(NG), .GW(GW), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .status_i (status),
    .rd_data  (rd_data),
    .en_mask  (en_mask)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    irqcmb_group #(.GW(GW)) u_grp (
      .clk   (clk),
      .rst   (rst),
      .pend  (status[g*GW +: GW]),
      .irq_o (grp_irq[g]),
      .idx_o (grp_idx[g*IDX_W +: IDX_W]),
      .vld_o (grp_vld[g])
    );
  end
endmodule

// File: rtl/irqcmb_chk.sv
module irqcmb_chk #(
  parameter int unsigned NG     = 4,
  parameter int unsigned GW     = 8,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned DW    = NG * GW,
  localparam int unsigned IDX_W = (GW > 1) ? $clog2(GW) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DW-1:0]       wr_data,
  input logic [DW-1:0]       en_mask,
  input logic [DW-1:0]       status,
  input logic [DW-1:0]       rd_data,
  input logic [NG-1:0]       grp_irq,
  input logic [NG*IDX_W-1:0] grp_idx,
  input logic [NG-1:0]       grp_vld
);
  logic is_set, is_clr, is_stat;
  assign is_set  = (32'(addr) == 32'h0);
  assign is_clr  = (32'(addr) == 32'h4);
  assign is_stat = (32'(addr) == 32'hC);

  logic [DW-1:0] st_q;
  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= status;
  end

  // R1: state right after reset
  p_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (en_mask == '0 && grp_irq == '0 && grp_vld == '0));

  // R2
  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_set) |=> ((en_mask & $past(wr_data)) == $past(wr_data))
                          && ((en_mask & ~$past(wr_data)) == ($past(en_mask) & ~$past(wr_data))));

  // R3
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_clr) |=> ((en_mask & $past(wr_data)) == '0)
                          && ((en_mask & ~$past(wr_data)) == ($past(en_mask) & ~$past(wr_data))));

  // R4
  p_status_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_stat) |=> rd_data == $past(status));

  // R7
  p_undef_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_set && !is_clr && !is_stat) |=> rd_data == '0);

  p_undef_wr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_set && !is_clr && !is_stat) |=> $stable(en_mask));

  // R8
  p_stat_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_stat) |=> $stable(en_mask));

  for (genvar g = 0; g < NG; g++) begin : g_chk
    logic [GW-1:0]    sl;
    logic [IDX_W-1:0] ix;
    logic [GW-1:0]    below;
    assign sl    = st_q[g*GW +: GW];
    assign ix    = grp_idx[g*IDX_W +: IDX_W];
    assign below = (GW'(1) << ix) - GW'(1);

    // R5
    p_or_r5: assert property (@(posedge clk) disable iff (rst)
      grp_irq[g] == (sl != '0));

    // R6
    p_idx_r6: assert property (@(posedge clk) disable iff (rst)
      grp_vld[g] |-> (sl[ix] && ((sl & below) == '0)));

    p_idx_zero_r6: assert property (@(posedge clk) disable iff (rst)
      !grp_vld[g] |-> (ix == '0 && sl == '0));
  end
endmodule

bind irqcmb_top irqcmb_chk #(.NG(NG), .GW(GW), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .en_mask (en_mask),
  .status  (status),
  .rd_data (rd_data),
  .grp_irq (grp_irq),
  .grp_idx (grp_idx),
  .grp_vld (grp_vld)
);

// File: tb/test_irqcmb_top.sv
module test_irqcmb_top;
  localparam int NG = 4;
  localparam int GW = 8;
  localparam int DW = NG * GW;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] irq_in = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NG-1:0] grp_irq;
  logic [NG*IW-1:0] grp_idx;
  logic [NG-1:0] grp_vld;

  always #2.5 clk = ~clk;

  irqcmb_top i_irqcmb_top (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .grp_irq(grp_irq), .grp_idx(grp_idx), .grp_vld(grp_vld)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] m_en = '0;

  function automatic logic [GW-1:0] pend_of(int g);
    logic [DW-1:0] s = irq_in & m_en;
    return s[g*GW +: GW];
  endfunction

  function automatic logic [IW-1:0] low_of(logic [GW-1:0] v);
    for (int i = 0; i < GW; i++) if (v[i]) return i[IW-1:0];
    return '0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 4'h0) m_en = m_en | d;
    else if (a == 4'h4) m_en = m_en & ~d;
  endtask

  task automatic rd(logic [3:0] a, string req, logic [DW-1:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, 64'(rd_data), 64'(exp));
  endtask

  // outputs settle one clock after the pending word changes
  task automatic check_groups();
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      logic [GW-1:0] p = pend_of(g);
      chk("R5 grp_irq", 64'(grp_irq[g]), 64'(p != '0));
      chk("R6 grp_vld", 64'(grp_vld[g]), 64'(p != '0));
      chk("R6 grp_idx", 64'(grp_idx[g*IW +: IW]), 64'(low_of(p)));
    end
  endtask

  task automatic set_irq(logic [DW-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 grp_irq", 64'(grp_irq), 64'h0);
    chk("R1 grp_vld", 64'(grp_vld), 64'h0);
    chk("R1 grp_idx", 64'(grp_idx), 64'h0);
    rd(4'h0, "R1 enable mask", '0);
    irq_in = '1;
    rd(4'hC, "R1 status with all disabled", '0);
    check_groups();

    // directed: R2 set, top and bottom bits
    wr(4'h0, 32'h8000_0001);
    rd(4'h0, "R2 set", 32'h8000_0001);
    check_groups();
    chk("R6 group3 top bit", 64'(grp_idx[3*IW +: IW]), 64'd7);
    chk("R6 group0 bottom bit", 64'(grp_idx[0 +: IW]), 64'd0);
    // several bits in group 1, lowest wins
    wr(4'h0, 32'h0000_A400);
    check_groups();
    chk("R6 group1 lowest of many", 64'(grp_idx[1*IW +: IW]), 64'd2);
    // clear beneath to move index
    wr(4'h4, 32'h0000_0400);
    rd(4'h4, "R3 clear read", 32'h8000_A001);
    check_groups();
    chk("R6 group1 index moves", 64'(grp_idx[1*IW +: IW]), 64'd5);
    // R4 level hold
    set_irq(32'h0000_2000);
    repeat (5) @(negedge clk);
    rd(4'hC, "R4 level held", 32'h0000_2000);
    check_groups();
    // R8, R7 ignored writes
    wr(4'hC, '1);
    rd(4'h0, "R8 status write ignored", m_en);
    wr(4'h8, '1);
    rd(4'h4, "R7 undefined write ignored", m_en);
    rd(4'h8, "R7 undefined read", '0);
    rd(4'hF, "R7 undefined read", '0);
    @(negedge clk);
    chk("R7 idle rd_data", 64'(rd_data), 64'h0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 5));
      logic [DW-1:0] d = $urandom();
      case (op)
        0: wr(4'h0, d);
        1: wr(4'h4, d);
        2: begin wr(4'hC, d); rd(4'h0, "R8 status write ignored", m_en); end
        3: begin wr(4'h8 | 4'($urandom_range(0, 1)), d); rd(4'h4, "R7 undefined write ignored", m_en); end
        4: set_irq((it % 3 == 0) ? (d & $urandom()) : d);
        default: begin
          logic [3:0] a = 4'($urandom_range(0, 15));
          logic [DW-1:0] e;
          if (a == 4'h0 || a == 4'h4) e = m_en;
          else if (a == 4'hC) e = irq_in & m_en;
          else e = '0;
          rd(a, (a == 4'hC) ? "R4 status read" : "R7 read", e);
        end
      endcase
      check_groups();
    end
    rd(4'hC, "R4 final status", irq_in & m_en);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule